// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

This block holds a small array of one-bit entries. A binary select picks one entry, a single data input supplies its value, and two active-low controls, a mode clear and an enable, choose one of four behaviours. With the clear inactive, the block is a bit-addressable working register: enabling writes the selected entry, and disabling freezes every entry. With the clear active, it is either a 1-of-N demultiplexer whose selected output carries the data bit while all others are low (enable active), or it forces every output low (enable inactive).

The model is synchronous. Storage and the demultiplexer word update on the rising clock edge; a parameter can instead route the demultiplexer word straight from the inputs to the outputs in the same cycle. Storage is emptied while the block demultiplexes or clears, so a later freeze shows zeros. A chip-level reset, separate from the mode clear, zeroes everything. Several instances can be stacked into a wider array by driving each one's enable from a decode of the upper address bits.

Top module: `addr_latch_demux`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every bit of `q` is 0 after that edge (registered output path).
- R2: With `clr_n`=1 and `en_n`=0 (write mode), after the edge `q[sel]` equals the `din` sampled at that edge.
- R3: In write mode every bit of `q` other than `q[sel]` keeps the value it had before the edge.
- R4: With `clr_n`=1 and `en_n`=1 (freeze mode), `q` does not change, whatever `sel` and `din` do.
- R5: With `clr_n`=0 and `en_n`=0 (demultiplexer mode), one edge later `q[sel]` equals `din` and all other bits of `q` are 0.
- R6: Demultiplexer mode empties the storage: a freeze that follows it shows `q` all zero.
- R7: With `clr_n`=0 and `en_n`=1 (clear mode), `q` is all zero after the edge and the storage is emptied, independent of `sel` and `din`.
- R8: `sel` is a plain binary index with bit `SEL_W-1` most significant: value 0 addresses `q[0]`, value 2^SEL_W-1 addresses the top bit.
- R9: With `DEMUX_COMB`=1, in demultiplexer mode `q` follows `sel` and `din` in the same cycle, without waiting for a clock edge; in the other modes it shows the storage as in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, zeroes all state |
| clr_n | input | 1 | Active-low mode clear |
| en_n | input | 1 | Active-low enable |
| sel | input | SEL_W | Binary entry index |
| din | input | 1 | Data bit |
| q | output | 2**SEL_W | Parallel outputs, bit i is entry i |

## Verification
The bench goes after the entries that a write must not touch: a decoder that writes a neighbour or clears the array on each write leaves wrong bits beside the addressed one. It checks the lowest and highest select values, which catch a reversed or off-by-one index. It checks the passage from demultiplexer mode back to freeze, where a design that kept the demultiplexer word in storage would show a stale one, and a write with data 0 after demultiplexing, where the old word must not leak back. The same-cycle variant is compared against the computed word before the clock edge, which a registered path would miss.

// File: rtl/alx_pkg.sv
// Shared types for the addressable latch.
// Assumes the two control inputs are active low.
package alx_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_FREEZE = 2'd1,
        MODE_DEMUX  = 2'd2,
        MODE_CLEAR  = 2'd3
    } alx_mode_e;

    // Map the clear/enable pair to an operating mode.
    function automatic alx_mode_e alx_decode(input logic clr_n, input logic en_n);
        alx_mode_e m;
        case ({clr_n, en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_FREEZE;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alx_mode_dec.sv
// Mode decoder: turns the active-low clear and enable into one mode value.
// Purely combinational; assumes inputs are already synchronous to clk.
module alx_mode_dec
    import alx_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output alx_mode_e mode
);

    // Decode the control pair.
    always_comb begin
        mode = alx_decode(clr_n, en_n);
    end

endmodule

// File: rtl/alx_index_dec.sv
// Index decoder: one-hot word with bit sel set.
// Assumes NUM equals 2**SEL_W so every select value maps to one bit.
module alx_index_dec #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned NUM   = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NUM-1:0]   hit
);

    for (genvar i = 0; i < NUM; i++) begin : g_hit
        // Compare the select against this entry's index.
        assign hit[i] = (sel == SEL_W'(i));
    end

endmodule

// File: rtl/alx_store.sv
// Entry storage: one flop per entry, written by the addressed hit in
// write mode, held in freeze mode, emptied in demux and clear modes.
// Assumes hit is one-hot.
module alx_store
    import alx_pkg::*;
#(
    parameter int unsigned NUM = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  alx_mode_e      mode,
    input  logic [NUM-1:0] hit,
    input  logic           din,
    output logic [NUM-1:0] store_q
);

    for (genvar i = 0; i < NUM; i++) begin : g_bit
        // Update entry i according to the current mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[i] <= 1'b0;
            end else begin
                case (mode)
                    MODE_WRITE:  if (hit[i]) store_q[i] <= din;
                    MODE_FREEZE: store_q[i] <= store_q[i];
                    default:     store_q[i] <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/alx_out_stage.sv
// Output stage: shows the storage, or the demultiplexer word while the
// block demultiplexes. COMB=0 registers the word; COMB=1 passes it from
// the inputs in the same cycle. Assumes hit is one-hot.
module alx_out_stage
    import alx_pkg::*;
#(
    parameter int unsigned NUM  = 8,
    parameter bit          COMB = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  alx_mode_e      mode,
    input  logic [NUM-1:0] hit,
    input  logic           din,
    input  logic [NUM-1:0] store_q,
    output logic [NUM-1:0] q
);

    logic [NUM-1:0] word_now;
    logic           dmx_now;
    logic [NUM-1:0] word_q;
    logic           dmx_q;

    // Form the demultiplexer word from the live inputs.
    always_comb begin
        dmx_now  = (mode == MODE_DEMUX);
        word_now = dmx_now ? (hit & {NUM{din}}) : '0;
    end

    // Register the word and whether it is being shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            dmx_q  <= 1'b0;
        end else begin
            word_q <= word_now;
            dmx_q  <= dmx_now;
        end
    end

    if (COMB) begin : g_comb
        // Same-cycle path for the demultiplexer word.
        assign q = dmx_now ? word_now : store_q;
    end else begin : g_reg
        // Registered path for the demultiplexer word.
        assign q = dmx_q ? word_q : store_q;
    end

endmodule

// File: rtl/addr_latch_demux.sv
// Addressable latch with demultiplexer mode (top).
// Four modes from clr_n/en_n: write, freeze, demux, clear. Storage and
// the registered demux word update on the rising edge of clk; rst_n is a
// synchronous active-low reset. Callers keep en_n high while sel moves.
module addr_latch_demux #(
    parameter int unsigned SEL_W      = 3,
    parameter bit          DEMUX_COMB = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  en_n,
    input  logic [SEL_W-1:0]      sel,
    input  logic                  din,
    output logic [(1<<SEL_W)-1:0] q
);

    import alx_pkg::*;

    localparam int unsigned NUM = 1 << SEL_W;

    alx_mode_e      mode;
    logic [NUM-1:0] hit;
    logic [NUM-1:0] store_q;

    alx_mode_dec i_mode_dec (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    alx_index_dec #(.SEL_W(SEL_W), .NUM(NUM)) i_index_dec (
        .sel (sel),
        .hit (hit)
    );

    alx_store #(.NUM(NUM)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .hit     (hit),
        .din     (din),
        .store_q (store_q)
    );

    alx_out_stage #(.NUM(NUM), .COMB(DEMUX_COMB)) i_out_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .hit     (hit),
        .din     (din),
        .store_q (store_q),
        .q       (q)
    );

endmodule

// File: rtl/alx_checker.sv
// Port-level properties of addr_latch_demux, bound to every instance.
// Checks apply to the registered output path only.
module alx_checker #(
    parameter int unsigned SEL_W      = 3,
    parameter bit          DEMUX_COMB = 1'b0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr_n,
    input logic                  en_n,
    input logic [SEL_W-1:0]      sel,
    input logic                  din,
    input logic [(1<<SEL_W)-1:0] q
);

    localparam int unsigned NUM = 1 << SEL_W;
    localparam bit          CHK = !DEMUX_COMB;

    logic wr_now, frz_now, dmx_now, clr_now;
    assign wr_now  =  clr_n && !en_n;
    assign frz_now =  clr_n &&  en_n;
    assign dmx_now = !clr_n && !en_n;
    assign clr_now = !clr_n &&  en_n;

    assert_reset_zero_R1: assert property (@(posedge clk)
        (CHK && !rst_n) |=> (q == '0));

    assert_write_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (CHK && wr_now) |=> (q[$past(sel)] == $past(din)));

    assert_write_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (CHK && wr_now && !$past(dmx_now))
        |=> (((q ^ $past(q)) & ~(NUM'(1) << $past(sel))) == '0));

    assert_freeze_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (CHK && frz_now && $past(frz_now)) |=> $stable(q));

    assert_demux_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (CHK && dmx_now)
        |=> (q[$past(sel)] == $past(din)) && ($countones(q) == ($past(din) ? 1 : 0)));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (CHK && clr_now) |=> (q == '0));

endmodule

bind addr_latch_demux alx_checker #(.SEL_W(SEL_W), .DEMUX_COMB(DEMUX_COMB)) i_alx_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .en_n  (en_n),
    .sel   (sel),
    .din   (din),
    .q     (q)
);

// File: tb/test_addr_latch_demux.sv
module test_addr_latch_demux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       en_n = 1'b1;
    logic [2:0] sel = '0;
    logic       din = 1'b0;
    logic [7:0] q;
    logic [7:0] q_c;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    addr_latch_demux #(.SEL_W(3), .DEMUX_COMB(1'b0)) i_addr_latch_demux (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
        .sel(sel), .din(din), .q(q)
    );

    addr_latch_demux #(.SEL_W(3), .DEMUX_COMB(1'b1)) i_addr_latch_demux_comb (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
        .sel(sel), .din(din), .q(q_c)
    );

    // Row: {req[3:0], clr_n, en_n, sel[2:0], din, expected q[7:0]}
    localparam logic [17:0] VEC [16] = '{
        {4'd2, 1'b1, 1'b0, 3'd3, 1'b1, 8'h08},  // R2 write entry 3
        {4'd3, 1'b1, 1'b0, 3'd0, 1'b1, 8'h09},  // R3/R8 entry 0, entry 3 kept
        {4'd8, 1'b1, 1'b0, 3'd7, 1'b1, 8'h89},  // R8 top index
        {4'd2, 1'b1, 1'b0, 3'd3, 1'b0, 8'h81},  // R2 write a zero
        {4'd4, 1'b1, 1'b1, 3'd5, 1'b1, 8'h81},  // R4 freeze ignores inputs
        {4'd4, 1'b1, 1'b1, 3'd0, 1'b0, 8'h81},  // R4
        {4'd5, 1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // R5 demux one-hot
        {4'd5, 1'b0, 1'b0, 3'd6, 1'b0, 8'h00},  // R5 demux data low
        {4'd5, 1'b0, 1'b0, 3'd5, 1'b1, 8'h20},  // R5
        {4'd6, 1'b1, 1'b1, 3'd1, 1'b1, 8'h00},  // R6 storage emptied
        {4'd3, 1'b1, 1'b0, 3'd1, 1'b1, 8'h02},  // R3
        {4'd3, 1'b1, 1'b0, 3'd6, 1'b1, 8'h42},  // R3
        {4'd7, 1'b0, 1'b1, 3'd4, 1'b1, 8'h00},  // R7 clear
        {4'd7, 1'b1, 1'b1, 3'd4, 1'b1, 8'h00},  // R7 storage emptied
        {4'd2, 1'b1, 1'b0, 3'd7, 1'b1, 8'h80},  // R2
        {4'd7, 1'b0, 1'b1, 3'd7, 1'b1, 8'h00}   // R7
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic e, input logic [2:0] s, input logic d);
        clr_n = c; en_n = e; sel = s; din = d;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] model;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1, q, 8'h00, "reset state");
        rst_n = 1'b1;

        // Table walk: inputs set at negedge, checked at the next negedge.
        for (int k = 0; k < 16; k++) begin
            drive(VEC[k][13], VEC[k][12], VEC[k][11:9], VEC[k][8]);
            #1;
            if (!VEC[k][13] && !VEC[k][12])  // R9 same-cycle demux word
                check(9, q_c, (8'h01 << VEC[k][11:9]) & {8{VEC[k][8]}}, "comb demux before edge");
            @(negedge clk);
            check(int'(VEC[k][17:14]), q, VEC[k][7:0], "vector");
            check(9, q_c, VEC[k][7:0], "comb variant after edge");
        end

        // R3/R8: walk every index in write mode against a model.
        drive(1'b0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        model = 8'h00;
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b0, 3'(i), 1'((i + 1) % 3 != 0));
            model[i] = 1'((i + 1) % 3 != 0);
            @(negedge clk);
            check(3, q, model, "index walk, others kept");
        end
        drive(1'b1, 1'b1, 3'd2, 1'b0);
        @(negedge clk);
        check(4, q, model, "freeze after walk");

        // R5 then write a zero: old demux word must not return.
        drive(1'b0, 1'b0, 3'd7, 1'b1);
        @(negedge clk);
        check(5, q, 8'h80, "demux top index");
        drive(1'b1, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        check(6, q, 8'h00, "write zero after demux");

        // R1: reset mid-run overrides a pending write.
        drive(1'b1, 1'b0, 3'd4, 1'b1);
        @(negedge clk);
        check(2, q, 8'h10, "write before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(1, q, 8'h00, "reset over write");
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 3'd0, 1'b0);
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule